// File: doc/BRIEF.md
# Digital XOR Phase Lock Detector

This block decides whether two slow, clock-like signals are aligned in phase and frequency. One is the divided reference and the other is the divided oscillator feedback. A fast system clock samples both. Each input passes through its own synchronizer. The block then XORs the two synchronized bits. The XOR is high for a fraction of each comparison period that grows linearly with the phase gap: no gap gives zero, a 180° gap gives the whole period.

A first-order recursive low-pass filter with a programmable shift turns that bit stream into an averaged error level. A comparator with hysteresis checks the level against a programmable threshold and drives a lock flag. The flag is high only when the two signals are aligned. It stays low while the filter settles after reset or after a configuration write. The filter corner is normally set roughly a decade below the smallest frequency offset that must be caught.

Top module: `phase_lock_monitor`

## Requirements
- R1: Each input passes through a two-flop synchronizer, and the phase error bit is the XOR of the two synchronized values.
- R2: The filter level (ACC_W+1 bits, full scale 2^ACC_W) updates every cycle as level += (err·2^ACC_W − level) >>> shift, with an arithmetic shift. It never exceeds 2^ACC_W.
- R3: While rst is high, lockOk is 0. Reset loads a threshold of 64 and a shift of DEF_SHIFT (4).
- R4: A cycle with cfgWr high loads cfgThr and cfgShift, clears the filter level to 0, drives lockOk to 0 at that edge, and restarts the settle interval.
- R5: lockOk stays 0 until 2^shift·8 system clocks have passed since reset or the last cfgWr. With shift 2 and a zero error, it rises exactly at the 33rd edge after the write edge.
- R6: The threshold level is thr·(2^ACC_W−1)/255. Code 255 is full scale (180°), code 0 is 0°, and code 64 is about 45°.
- R7: While locked, a filter level strictly above the threshold level drops lockOk on the next edge.
- R8: While unlocked and settled, lockOk rises only once level + 2^ACC_W/32 ≤ threshold level. A level between the two limits keeps the current state.
- R9: With threshold code 0, lockOk never goes high, even with identical inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | Divided reference signal |
| fbIn | input | 1 | Divided oscillator feedback signal |
| cfgWr | input | 1 | Configuration write strobe |
| cfgThr | input | 8 | Phase threshold code (0 = 0°, 255 = 180°) |
| cfgShift | input | 4 | Filter shift (time constant 2^shift clocks) |
| lockOk | output | 1 | High when locked, low when out of lock or settling |

## Verification
The bench keeps the default ACC_W of 16, so the threshold scale is exactly 257 counts per code and the hysteresis band is 2048 counts. The comparison period is 16 or 8 system clocks, and the bench offsets the feedback by whole clocks to place the XOR duty at chosen fractions. A shift of 8 gives short settle windows for sweeping many threshold and phase pairs. A shift of 2 makes the exact settle edge observable. A shift of 10 with an 8-clock period holds the filter ripple to under 100 counts, so a duty of one quarter sits inside the hysteresis band with default threshold 64. That lets the bench show the flag holding its state in both directions.

// File: rtl/plm_pkg.sv
package plm_pkg;
  localparam int SHIFT_W = 4;
  localparam int THR_W   = 8;

  // Strobes and settings handed from control to datapath
  typedef struct packed {
    logic               accClear;
    logic [SHIFT_W-1:0] shift;
    logic [THR_W-1:0]   thr;
  } plm_ctrl_t;

  // Comparison results handed from datapath to control
  typedef struct packed {
    logic overThr;
    logic inLockZone;
  } plm_stat_t;
endpackage

// File: rtl/plm_datapath.sv
module plm_datapath
  import plm_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refIn,
  input  logic             fbIn,
  input  plm_ctrl_t        ctrl,
  output plm_stat_t        stat,
  output logic [ACC_W:0]   accLevel,
  output logic [ACC_W-1:0] thrLevel
);
  localparam int EXT_W = ACC_W + 2;
  localparam int SCALE = ((1 << ACC_W) - 1) / ((1 << THR_W) - 1);
  localparam int HYST  = 1 << (ACC_W - 5);

  logic [1:0] rawIn;
  logic [1:0] syncOut;
  assign rawIn = {fbIn, refIn};

  // One synchronizer chain per input channel
  for (genvar ch = 0; ch < 2; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] stages;
    always_ff @(posedge clk) begin
      if (rst) stages <= '0;
      else     stages <= {stages[SYNC_STAGES-2:0], rawIn[ch]};
    end
    assign syncOut[ch] = stages[SYNC_STAGES-1];
  end

  logic phaseErr;
  assign phaseErr = syncOut[0] ^ syncOut[1];

  // First-order recursive average of the error bit
  logic [ACC_W:0]          acc;
  logic signed [EXT_W-1:0] goal, diff, step, sum;

  always_comb begin
    goal = $signed({1'b0, phaseErr, {ACC_W{1'b0}}});
    diff = goal - $signed({1'b0, acc});
    step = diff >>> ctrl.shift;
    sum  = $signed({1'b0, acc}) + step;
  end

  always_ff @(posedge clk) begin
    if (rst || ctrl.accClear) acc <= '0;
    else                      acc <= sum[ACC_W:0];
  end

  // Linear threshold scaling and hysteresis comparisons
  assign thrLevel = ACC_W'(ctrl.thr) * ACC_W'(SCALE);
  assign accLevel = acc;

  always_comb begin
    stat.overThr    = {1'b0, acc} > EXT_W'(thrLevel);
    stat.inLockZone = ({1'b0, acc} + EXT_W'(HYST)) <= EXT_W'(thrLevel);
  end
endmodule

// File: rtl/plm_control.sv
module plm_control
  import plm_pkg::*;
#(
  parameter int DEF_SHIFT = 4,
  parameter int DEF_THR   = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfgWr,
  input  logic [THR_W-1:0]   cfgThr,
  input  logic [SHIFT_W-1:0] cfgShift,
  input  plm_stat_t          stat,
  output plm_ctrl_t          ctrl,
  output logic               lockOk
);
  localparam int CNT_W = (1 << SHIFT_W) + 3;

  typedef enum logic [1:0] {ST_SETTLE, ST_UNLOCKED, ST_LOCKED} plm_state_e;

  plm_state_e         state;
  logic [THR_W-1:0]   thrReg;
  logic [SHIFT_W-1:0] shiftReg;
  logic [CNT_W-1:0]   settleCnt;
  logic [CNT_W-1:0]   settleTarget;
  logic               settled;

  assign settleTarget = CNT_W'(1) << (32'(shiftReg) + 3);
  assign settled      = settleCnt == settleTarget;

  always_ff @(posedge clk) begin
    if (rst) begin
      thrReg    <= THR_W'(DEF_THR);
      shiftReg  <= SHIFT_W'(DEF_SHIFT);
      settleCnt <= '0;
      state     <= ST_SETTLE;
    end else if (cfgWr) begin
      thrReg    <= cfgThr;
      shiftReg  <= cfgShift;
      settleCnt <= '0;
      state     <= ST_SETTLE;
    end else begin
      case (state)
        ST_SETTLE: begin
          if (settled) state <= stat.inLockZone ? ST_LOCKED : ST_UNLOCKED;
          else         settleCnt <= settleCnt + 1'b1;
        end
        ST_UNLOCKED: if (stat.inLockZone) state <= ST_LOCKED;
        ST_LOCKED:   if (stat.overThr)    state <= ST_UNLOCKED;
        default:     state <= ST_SETTLE;
      endcase
    end
  end

  always_comb begin
    ctrl.accClear = cfgWr;
    ctrl.shift    = shiftReg;
    ctrl.thr      = thrReg;
  end

  assign lockOk = state == ST_LOCKED;
endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
  import plm_pkg::*;
#(
  parameter int ACC_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DEF_SHIFT   = 4,
  parameter int DEF_THR     = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               refIn,
  input  logic               fbIn,
  input  logic               cfgWr,
  input  logic [THR_W-1:0]   cfgThr,
  input  logic [SHIFT_W-1:0] cfgShift,
  output logic               lockOk
);
  plm_ctrl_t        ctrl;
  plm_stat_t        stat;
  logic [ACC_W:0]   accLevel;
  logic [ACC_W-1:0] thrLevel;

  plm_datapath #(.ACC_W(ACC_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn),
    .ctrl(ctrl), .stat(stat), .accLevel(accLevel), .thrLevel(thrLevel)
  );

  plm_control #(.DEF_SHIFT(DEF_SHIFT), .DEF_THR(DEF_THR)) u_ctl (
    .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgThr(cfgThr),
    .cfgShift(cfgShift), .stat(stat), .ctrl(ctrl), .lockOk(lockOk)
  );
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int ACC_W     = 16,
  parameter int DEF_SHIFT = 4,
  parameter int SHIFT_W   = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               cfgWr,
  input logic [SHIFT_W-1:0] cfgShift,
  input logic               lockOk,
  input logic [ACC_W:0]     accLvl,
  input logic [ACC_W-1:0]   thrLvl
);
  localparam int HYST = 1 << (ACC_W - 5);

  logic [SHIFT_W-1:0] shiftC;
  logic [31:0]        sinceCfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftC   <= SHIFT_W'(DEF_SHIFT);
      sinceCfg <= '0;
    end else if (cfgWr) begin
      shiftC   <= cfgShift;
      sinceCfg <= '0;
    end else if (sinceCfg != 32'hFFFF_FFFF) begin
      sinceCfg <= sinceCfg + 1;
    end
  end

  a_r3_low_in_reset: assert property (@(posedge clk) rst |=> !lockOk);

  a_r4_cfg_drops_lock: assert property (@(posedge clk) disable iff (rst)
    cfgWr |=> !lockOk);

  a_r5_settle_window: assert property (@(posedge clk) disable iff (rst)
    lockOk |-> sinceCfg > (32'd1 << (32'(shiftC) + 3)));

  a_r2_level_bounded: assert property (@(posedge clk) disable iff (rst)
    32'(accLvl) <= (32'd1 << ACC_W));

  a_r8_lock_entry: assert property (@(posedge clk) disable iff (rst)
    $rose(lockOk) |-> (32'($past(accLvl)) + HYST <= 32'($past(thrLvl))));

  a_r7_unlock_cause: assert property (@(posedge clk) disable iff (rst)
    $fell(lockOk) |-> ($past(cfgWr) || (32'($past(accLvl)) > 32'($past(thrLvl)))));
endmodule

bind phase_lock_monitor plm_checker #(.ACC_W(ACC_W), .DEF_SHIFT(DEF_SHIFT)) u_chk (
  .clk(clk), .rst(rst), .cfgWr(cfgWr), .cfgShift(cfgShift),
  .lockOk(lockOk), .accLvl(accLevel), .thrLvl(thrLevel)
);

// File: tb/test_phase_lock_monitor.sv
`timescale 1ns/1ps
module test_phase_lock_monitor;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       refIn = 1'b0;
  logic       fbIn = 1'b0;
  logic       cfgWr = 1'b0;
  logic [7:0] cfgThr = 8'd0;
  logic [3:0] cfgShift = 4'd0;
  logic       lockOk;

  int testCount = 0;
  int failCount = 0;
  int per = 16;
  int dly = 0;
  int ph  = 0;

  phase_lock_monitor i_phase_lock_monitor (
    .clk(clk), .rst(rst), .refIn(refIn), .fbIn(fbIn), .cfgWr(cfgWr),
    .cfgThr(cfgThr), .cfgShift(cfgShift), .lockOk(lockOk)
  );

  always #10 clk = ~clk;

  // Square waves: feedback lags reference by dly system clocks
  always @(negedge clk) begin
    ph    = (ph + 1) % per;
    refIn = ph < per / 2;
    fbIn  = ((ph + per - dly) % per) < per / 2;
  end

  // thr, delay, expected lock (period 16, shift 8)
  localparam int NVEC = 8;
  localparam int VEC [NVEC][3] = '{
    '{64, 0, 1},   // R6 zero phase
    '{64, 1, 1},   // R6 duty 1/8 below 45 deg
    '{64, 3, 0},   // R7 duty 3/8 above 45 deg
    '{64, 8, 0},   // R7 inverted, full scale
    '{128, 3, 1},  // R6 duty 3/8 below 90 deg
    '{128, 5, 0},  // R7 duty 5/8 above 90 deg
    '{255, 4, 1},  // R6 half duty under full scale
    '{0, 0, 0}     // R9 zero threshold never locks
  };

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: lockOk=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int thr, input int sh);
    @(negedge clk);
    cfgWr    = 1'b1;
    cfgThr   = 8'(thr);
    cfgShift = 4'(sh);
    @(negedge clk);
    cfgWr    = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    // R3: flag low under reset, defaults shift 4 (128 clocks) and thr 64
    per = 16; dly = 0;
    waitCycles(5);
    check("R3 reset", lockOk, 1'b0);
    rst = 1'b0;
    waitCycles(128);
    check("R3 default settle", lockOk, 1'b0);
    waitCycles(1);
    check("R3 default lock", lockOk, 1'b1);

    // R4 and R5: write drops lock, exact settle edge with shift 2
    cfgWrite(64, 2);
    check("R4 cfg drop", lockOk, 1'b0);
    waitCycles(32);
    check("R5 before settle", lockOk, 1'b0);
    waitCycles(1);
    check("R5 after settle", lockOk, 1'b1);

    // Table walk: R1 R6 R7 R9 across phase and threshold pairs
    for (int i = 0; i < NVEC; i++) begin
      dly = VEC[i][1];
      cfgWrite(VEC[i][0], 8);
      waitCycles(3000);
      check($sformatf("R6/R7/R9 vector %0d", i), lockOk, 1'(VEC[i][2]));
    end

    // R8 hysteresis: period 8, shift 10, thr 64
    per = 8; dly = 0;
    cfgWrite(64, 10);
    waitCycles(12000);
    check("R8 lock at zero phase", lockOk, 1'b1);
    dly = 1;
    waitCycles(12000);
    check("R8 band holds lock", lockOk, 1'b1);
    dly = 2;
    waitCycles(12000);
    check("R7 half duty unlocks", lockOk, 1'b0);
    dly = 1;
    waitCycles(12000);
    check("R8 band holds unlock", lockOk, 1'b0);
    dly = 0;
    waitCycles(12000);
    check("R8 relock", lockOk, 1'b1);
    cfgWrite(64, 10);
    check("R4 cfg drop locked", lockOk, 1'b0);

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule